// File: doc/BRIEF.md
# Stack Operation Decode Unit

This unit sits in the decode stage of a five-stage in-order pipeline. It turns the opcode and the two register fields of each instruction into the control word that travels down the pipeline. For the four stack instructions (push, pop, call and return), it substitutes the stack-pointer register where the second register operand would normally go. It chooses a constant of 8 as the ALU operand, and it selects add or subtract so that the stack pointer moves in the right direction. It also picks where the memory address comes from, and it sets the read and write enables. Finally it names the two writeback destinations and tells fetch where the next PC comes from.

A push-like instruction (push, call) stores at the decremented stack pointer, so its memory address is the ALU result. A pop-like instruction (pop, return) loads from the stack pointer it started with, so its address is the unmodified operand. A pop updates two registers in one instruction: the stack pointer through the execute-result destination, and its target register through the memory-result destination. Every other opcode passes its register fields straight through. The control word is registered once, so it appears one clock after the instruction is presented. Forwarding, hazard detection, the register file and memory are outside this unit.

Top module: `stk_decode_unit`

## Requirements
- R1: After reset, and in the cycle after `in_valid` is low, `out_valid` is 0. Both sources and both destinations are 15 (no register). `out_alu_a_sel`, `out_alu_sub`, `out_mem_rd`, `out_mem_wr`, `out_maddr_old`, `out_wdata_valp` and `out_pc_sel` are all 0.
- R2: An instruction presented with `in_valid` high at one rising edge produces its control word, with `out_valid` high, right after that edge. The latency is one cycle.
- R3: Push (opcode 0xA) gives the following control word:
  - sources: `src_a = ra`, `src_b` = stack pointer (register 4);
  - ALU: `alu_a_sel = 2` (constant 8), `alu_sub = 1`;
  - memory: `mem_wr = 1`, `mem_rd = 0`, `maddr_old = 0` (address is the new stack pointer), `wdata_valp = 0`;
  - destinations: `dst_e` = 4, `dst_m` = 15;
  - next PC: `pc_sel = 0` (fall-through).
- R4: Pop (opcode 0xB) gives the following control word:
  - sources: both are 4;
  - ALU: `alu_a_sel = 2`, `alu_sub = 0`;
  - memory: `mem_rd = 1`, `mem_wr = 0`, `maddr_old = 1` (address is the old stack pointer);
  - destinations: `dst_e = 4`, `dst_m = ra`;
  - next PC: `pc_sel = 0`.
- R5: When a pop names register 4 in `ra`, the memory result must win. `dst_m` is 4 and `dst_e` is 15.
- R6: Call (opcode 0x8) gives the following control word:
  - sources: `src_a = 15`, `src_b = 4`;
  - ALU: `alu_a_sel = 2`, `alu_sub = 1`;
  - memory: `mem_wr = 1`, `maddr_old = 0`, `wdata_valp = 1` (the fall-through address is stored);
  - destinations: `dst_e = 4`, `dst_m = 15`;
  - next PC: `pc_sel = 1` (immediate target).
- R7: Return (opcode 0x9) gives the following control word:
  - sources: both are 4;
  - ALU: `alu_a_sel = 2`, `alu_sub = 0`;
  - memory: `mem_rd = 1`, `maddr_old = 1`;
  - destinations: `dst_e = 4`, `dst_m = 15`;
  - next PC: `pc_sel = 2` (loaded value).
- R8: Any other opcode gives the following control word:
  - sources: `src_a = ra`, `src_b = rb`;
  - destinations: `dst_e = rb`, `dst_m = 15`;
  - everything else is 0.
- R9: `out_mem_rd` and `out_mem_wr` are never high together. When `dst_m` names a register, `dst_e` never names the same one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_opc | input | 4 | Instruction opcode |
| in_ra | input | 4 | First register field |
| in_rb | input | 4 | Second register field |
| out_valid | output | 1 | Control word is valid |
| out_src_a | output | 4 | First register-read select (15 = none) |
| out_src_b | output | 4 | Second register-read select (15 = none) |
| out_dst_e | output | 4 | Execute-result destination (15 = none) |
| out_dst_m | output | 4 | Memory-result destination (15 = none) |
| out_alu_a_sel | output | 2 | ALU operand A: 0 register value, 2 constant 8 |
| out_alu_sub | output | 1 | ALU subtracts operand A from operand B |
| out_mem_rd | output | 1 | Memory read enable |
| out_mem_wr | output | 1 | Memory write enable |
| out_maddr_old | output | 1 | Address from old stack pointer (1) or ALU result (0) |
| out_wdata_valp | output | 1 | Write data is fall-through address (1) or register value (0) |
| out_pc_sel | output | 2 | Next PC: 0 fall-through, 1 immediate target, 2 loaded value |

## Verification
Every control word is due exactly one rising edge after its instruction is presented. The bench drives inputs on the falling edge. It compares the outputs on the next falling edge, after the single capture edge and before the following input is applied. The sweep covers every opcode and every pair of register fields back to back, so a wrong field or a stale value from the previous instruction shows up at once. Bubbles are placed between groups, and reset is applied at the end, so that the idle word is checked in the cycle it is due.

// File: rtl/stk_dec_pkg.sv
package stk_dec_pkg;

    localparam int OPC_W = 4;
    localparam int REG_W = 4;

    localparam logic [OPC_W-1:0] OPC_CALL = 4'h8;
    localparam logic [OPC_W-1:0] OPC_RET  = 4'h9;
    localparam logic [OPC_W-1:0] OPC_PUSH = 4'hA;
    localparam logic [OPC_W-1:0] OPC_POP  = 4'hB;

    typedef enum logic [1:0] {
        ASEL_REGA   = 2'd0,
        ASEL_CONST8 = 2'd2
    } asel_e;

    typedef enum logic [1:0] {
        PC_SEQ    = 2'd0,
        PC_TARGET = 2'd1,
        PC_MEMVAL = 2'd2
    } pcsel_e;

    typedef enum logic [2:0] {
        K_OTHER = 3'd0,
        K_PUSH  = 3'd1,
        K_POP   = 3'd2,
        K_CALL  = 3'd3,
        K_RET   = 3'd4
    } kind_e;

    typedef struct packed {
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic [REG_W-1:0] dst_e;
        logic [REG_W-1:0] dst_m;
        asel_e            alu_a;
        logic             alu_sub;
        logic             mem_rd;
        logic             mem_wr;
        logic             maddr_old;
        logic             wdata_valp;
        pcsel_e           pc_sel;
    } ctl_t;

    function automatic kind_e classify(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_PUSH: return K_PUSH;
            OPC_POP:  return K_POP;
            OPC_CALL: return K_CALL;
            OPC_RET:  return K_RET;
            default:  return K_OTHER;
        endcase
    endfunction

    function automatic ctl_t idle_word(input logic [REG_W-1:0] none_id);
        ctl_t w;
        w.src_a      = none_id;
        w.src_b      = none_id;
        w.dst_e      = none_id;
        w.dst_m      = none_id;
        w.alu_a      = ASEL_REGA;
        w.alu_sub    = 1'b0;
        w.mem_rd     = 1'b0;
        w.mem_wr     = 1'b0;
        w.maddr_old  = 1'b0;
        w.wdata_valp = 1'b0;
        w.pc_sel     = PC_SEQ;
        return w;
    endfunction

endpackage

// File: rtl/stk_kind_dec.sv
module stk_kind_dec
    import stk_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output kind_e            kind,
    output logic             push_like,
    output logic             pop_like
);
    always_comb begin
        kind      = classify(opc);
        push_like = (kind == K_PUSH) || (kind == K_CALL);
        pop_like  = (kind == K_POP)  || (kind == K_RET);
    end
endmodule

// File: rtl/stk_reg_sel.sv
module stk_reg_sel
    import stk_dec_pkg::*;
#(
    parameter logic [REG_W-1:0] SP_ID   = 4'd4,
    parameter logic [REG_W-1:0] NONE_ID = 4'd15
) (
    input  kind_e            kind,
    input  logic [REG_W-1:0] ra,
    input  logic [REG_W-1:0] rb,
    output logic [REG_W-1:0] src_a,
    output logic [REG_W-1:0] src_b,
    output logic [REG_W-1:0] dst_e,
    output logic [REG_W-1:0] dst_m
);
    logic pop_hits_sp;
    assign pop_hits_sp = (ra == SP_ID);

    always_comb begin
        src_a = ra;
        src_b = rb;
        dst_e = rb;
        dst_m = NONE_ID;
        unique case (kind)
            K_PUSH: begin
                src_b = SP_ID;
                dst_e = SP_ID;
            end
            K_CALL: begin
                src_a = NONE_ID;
                src_b = SP_ID;
                dst_e = SP_ID;
            end
            K_POP: begin
                src_a = SP_ID;
                src_b = SP_ID;
                dst_m = ra;
                dst_e = pop_hits_sp ? NONE_ID : SP_ID;
            end
            K_RET: begin
                src_a = SP_ID;
                src_b = SP_ID;
                dst_e = SP_ID;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_exec_sel.sv
module stk_exec_sel
    import stk_dec_pkg::*;
(
    input  kind_e  kind,
    input  logic   push_like,
    input  logic   pop_like,
    output asel_e  alu_a,
    output logic   alu_sub,
    output logic   mem_rd,
    output logic   mem_wr,
    output logic   maddr_old,
    output logic   wdata_valp,
    output pcsel_e pc_sel
);
    always_comb begin
        alu_a      = (push_like || pop_like) ? ASEL_CONST8 : ASEL_REGA;
        alu_sub    = push_like;
        mem_wr     = push_like;
        mem_rd     = pop_like;
        maddr_old  = pop_like;
        wdata_valp = (kind == K_CALL);
        case (kind)
            K_CALL:  pc_sel = PC_TARGET;
            K_RET:   pc_sel = PC_MEMVAL;
            default: pc_sel = PC_SEQ;
        endcase
    end
endmodule

// File: rtl/stk_decode_unit.sv
module stk_decode_unit
    import stk_dec_pkg::*;
#(
    parameter logic [REG_W-1:0] SP_ID   = 4'd4,
    parameter logic [REG_W-1:0] NONE_ID = 4'd15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OPC_W-1:0] in_opc,
    input  logic [REG_W-1:0] in_ra,
    input  logic [REG_W-1:0] in_rb,
    output logic             out_valid,
    output logic [REG_W-1:0] out_src_a,
    output logic [REG_W-1:0] out_src_b,
    output logic [REG_W-1:0] out_dst_e,
    output logic [REG_W-1:0] out_dst_m,
    output logic [1:0]       out_alu_a_sel,
    output logic             out_alu_sub,
    output logic             out_mem_rd,
    output logic             out_mem_wr,
    output logic             out_maddr_old,
    output logic             out_wdata_valp,
    output logic [1:0]       out_pc_sel
);
    kind_e kind;
    logic  push_like, pop_like;
    ctl_t  next_w, word_q;

    stk_kind_dec u_kind (
        .opc       (in_opc),
        .kind      (kind),
        .push_like (push_like),
        .pop_like  (pop_like)
    );

    stk_reg_sel #(.SP_ID(SP_ID), .NONE_ID(NONE_ID)) u_regs (
        .kind  (kind),
        .ra    (in_ra),
        .rb    (in_rb),
        .src_a (next_w.src_a),
        .src_b (next_w.src_b),
        .dst_e (next_w.dst_e),
        .dst_m (next_w.dst_m)
    );

    stk_exec_sel u_exec (
        .kind       (kind),
        .push_like  (push_like),
        .pop_like   (pop_like),
        .alu_a      (next_w.alu_a),
        .alu_sub    (next_w.alu_sub),
        .mem_rd     (next_w.mem_rd),
        .mem_wr     (next_w.mem_wr),
        .maddr_old  (next_w.maddr_old),
        .wdata_valp (next_w.wdata_valp),
        .pc_sel     (next_w.pc_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            word_q    <= idle_word(NONE_ID);
        end else begin
            out_valid <= in_valid;
            word_q    <= in_valid ? next_w : idle_word(NONE_ID);
        end
    end

    assign out_src_a      = word_q.src_a;
    assign out_src_b      = word_q.src_b;
    assign out_dst_e      = word_q.dst_e;
    assign out_dst_m      = word_q.dst_m;
    assign out_alu_a_sel  = word_q.alu_a;
    assign out_alu_sub    = word_q.alu_sub;
    assign out_mem_rd     = word_q.mem_rd;
    assign out_mem_wr     = word_q.mem_wr;
    assign out_maddr_old  = word_q.maddr_old;
    assign out_wdata_valp = word_q.wdata_valp;
    assign out_pc_sel     = word_q.pc_sel;
endmodule

// File: rtl/stk_decode_chk.sv
module stk_decode_chk
    import stk_dec_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OPC_W-1:0] in_opc,
    input logic [REG_W-1:0] in_ra,
    input logic [REG_W-1:0] in_rb,
    input logic             out_valid,
    input logic [REG_W-1:0] out_dst_e,
    input logic [REG_W-1:0] out_dst_m,
    input logic             out_alu_sub,
    input logic             out_mem_rd,
    input logic             out_mem_wr,
    input logic             out_maddr_old,
    input logic [1:0]       out_pc_sel
);
    // R9
    rw_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_mem_rd && out_mem_wr));

    // R9
    dst_distinct_chk: assert property (@(posedge clk) disable iff (rst)
        (out_dst_m != 4'd15) |-> (out_dst_e != out_dst_m));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_mem_rd && !out_mem_wr && out_pc_sel == 2'd0));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R3
    push_new_sp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_opc == OPC_PUSH) |=> (out_mem_wr && out_alu_sub && !out_maddr_old));

    // R4
    pop_old_sp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_opc == OPC_POP) |=> (out_mem_rd && out_maddr_old && !out_alu_sub));

    // R7
    ret_loads_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (out_pc_sel == 2'd2) |-> out_mem_rd);
endmodule

bind stk_decode_unit stk_decode_chk u_chk (.*);

// File: tb/tb_stk_decode_unit.sv
module tb_stk_decode_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] in_opc = '0, in_ra = '0, in_rb = '0;
    logic       out_valid;
    logic [3:0] out_src_a, out_src_b, out_dst_e, out_dst_m;
    logic [1:0] out_alu_a_sel, out_pc_sel;
    logic       out_alu_sub, out_mem_rd, out_mem_wr, out_maddr_old, out_wdata_valp;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stk_decode_unit dut (.*);

    localparam logic [3:0] SP = 4'd4, NO = 4'd15;

    function automatic logic [25:0] got_word();
        return {out_valid, out_src_a, out_src_b, out_dst_e, out_dst_m, out_alu_a_sel,
                out_alu_sub, out_mem_rd, out_mem_wr, out_maddr_old, out_wdata_valp, out_pc_sel};
    endfunction

    function automatic logic [25:0] mk(input logic v, input logic [3:0] sa, sb, de, dm,
                                       input logic [1:0] asel, input logic sub, rd, wr,
                                       old, vp, input logic [1:0] pc);
        return {v, sa, sb, de, dm, asel, sub, rd, wr, old, vp, pc};
    endfunction

    function automatic logic [25:0] expect_word(input logic [3:0] op, ra, rb);
        case (op)
            4'hA: return mk(1, ra, SP, SP, NO, 2, 1, 0, 1, 0, 0, 0);
            4'hB: return mk(1, SP, SP, (ra == SP) ? NO : SP, ra, 2, 0, 1, 0, 1, 0, 0);
            4'h8: return mk(1, NO, SP, SP, NO, 2, 1, 0, 1, 0, 1, 1);
            4'h9: return mk(1, SP, SP, SP, NO, 2, 0, 1, 0, 1, 0, 2);
            default: return mk(1, ra, rb, rb, NO, 0, 0, 0, 0, 0, 0, 0);
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op, ra);
        case (op)
            4'hA: return "R3";
            4'hB: return (ra == SP) ? "R5" : "R4";
            4'h8: return "R6";
            4'h9: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [25:0] exp);
        logic [25:0] got = got_word();
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    localparam logic [25:0] IDLE = {1'b0, NO, NO, NO, NO, 2'd0, 5'd0, 2'd0};

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", IDLE);
        for (int op = 0; op < 16; op++) begin
            for (int ra = 0; ra < 16; ra++) begin
                for (int rb = 0; rb < 16; rb++) begin
                    in_valid = 1'b1;
                    in_opc = 4'(op); in_ra = 4'(ra); in_rb = 4'(rb);
                    @(negedge clk);
                    // R2 word due one edge later; R9 covered by pop/push words
                    check(req_of(4'(op), 4'(ra)), expect_word(4'(op), 4'(ra), 4'(rb)));
                end
                // R1 bubble after each group, with stack opcode held on the inputs
                in_valid = 1'b0;
                in_opc = 4'hB;
                @(negedge clk);
                check("R1", IDLE);
            end
        end
        // R2 valid back-to-back after bubble: push then return
        in_valid = 1'b1; in_opc = 4'hA; in_ra = 4'd3; in_rb = 4'd7;
        @(negedge clk);
        check("R2", expect_word(4'hA, 4'd3, 4'd7));
        in_opc = 4'h9;
        @(negedge clk);
        check("R2", expect_word(4'h9, 4'd3, 4'd7));
        // R1 reset with valid input held
        rst = 1'b1;
        @(negedge clk);
        check("R1", IDLE);
        rst = 1'b0; in_valid = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule